// File: doc/BRIEF.md
# XNOR Maximal-Length Sequence Generator

This block produces a pseudo-random bit pattern from a shift register whose width is a parameter (3 to 8 bits). Each clock cycle with the enable input high, the register shifts one place toward its most significant end. The XNOR of a fixed set of tapped bits enters at bit 0. The taps are chosen so that the register walks through every pattern except all-ones before it repeats, which gives a period of 2^W−1 steps.

XNOR feedback makes the all-zero state a normal member of the sequence, so the register leaves reset at zero and runs at once. A seed strobe replaces the register contents with an input word at any time. A one-cycle done flag marks each return to the value the current period started from. That value is the last loaded seed, or zero after reset.

Top module: `xnor_lfsr_gen`

## Requirements
- R1: A synchronous active-high reset sets the state output to all zeros and holds done low in the cycle after it.
- R2: In a cycle with step_en high and seed_load low, the state advances to {state[W-2:0], fb}. fb is the XNOR of the tapped bits, taken at 1-based positions 3:{3,2}, 4:{4,3}, 5:{5,3}, 6:{6,5}, 7:{7,6}, 8:{8,6,5,4}. For the default W=5, fb = ~(state[4] ^ state[2]).
- R3: In a cycle with step_en and seed_load both low, the state output does not change and done is low.
- R4: When seed_load is high, seed_word appears on the state output after that clock edge, whatever step_en is. A load takes the place of a step in the same cycle and never raises done.
- R5: Starting from zero, 2^W−1 consecutive enabled steps visit 2^W−1 distinct states and then return to zero.
- R6: The all-ones pattern never appears when the register starts from zero. If all-ones is loaded as a seed, the state stays all-ones through enabled steps.
- R7: done is high for one cycle, in the same cycle the state output shows the result of an enabled step that equals the period's start value. The start value is the last loaded seed, or zero after reset. done is low in every other cycle.
- R8: A width outside 3..8 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the register this cycle |
| seed_load | input | 1 | Load seed_word this cycle (wins over a step) |
| seed_word | input | W | Value to load |
| state | output | W | Current register contents |
| done | output | 1 | One-cycle pulse at the end of each full period |

## Verification
Two actions can fall in the same cycle: a seed load and an enabled step. The sharpest case is the step that would complete a period and raise done. The bench runs a period from a seed up to its final cycle, then raises seed_load together with step_en. It expects the new seed on the state output, done low, and a fresh period counted from the new seed. A reference model, built from integer arithmetic on the tap equation, checks every clock, and a visited-state table confirms the full period and that all-ones never appears.

// File: rtl/xlfsr_pkg.sv
package xlfsr_pkg;

    localparam int MIN_W = 3;
    localparam int MAX_W = 8;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;

    function automatic bit width_ok(input int w);
        return (w >= MIN_W) && (w <= MAX_W);
    endfunction

    // Bit i set means register bit i feeds the XNOR (1-based position i+1).
    function automatic logic [MAX_W-1:0] tap_mask(input int w);
        logic [MAX_W-1:0] m;
        case (w)
            3:       m = 8'b0000_0110;
            4:       m = 8'b0000_1100;
            5:       m = 8'b0001_0100;
            6:       m = 8'b0011_0000;
            7:       m = 8'b0110_0000;
            8:       m = 8'b1011_1000;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xlfsr_next.sv
module xlfsr_next
    import xlfsr_pkg::*;
#(
    parameter int W = 5
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam logic [MAX_W-1:0] MASK_FULL = tap_mask(W);
    localparam logic [W-1:0]     MASK      = MASK_FULL[W-1:0];

    logic fb;

    always_comb begin
        fb  = ~^(cur & MASK);
        nxt = {cur[W-2:0], fb};
    end
endmodule

// File: rtl/xlfsr_ctl.sv
module xlfsr_ctl
    import xlfsr_pkg::*;
(
    input  logic rst,
    input  logic step_en,
    input  logic seed_load,
    output act_e act
);
    always_comb begin
        if (rst)            act = ACT_CLEAR;
        else if (seed_load) act = ACT_LOAD;
        else if (step_en)   act = ACT_STEP;
        else                act = ACT_HOLD;
    end
endmodule

// File: rtl/xlfsr_period.sv
module xlfsr_period
    import xlfsr_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  act_e         act,
    input  logic [W-1:0] seed_word,
    input  logic [W-1:0] nxt,
    output logic         done
);
    logic [W-1:0] start_q;

    always_ff @(posedge clk) begin
        case (act)
            ACT_CLEAR: begin
                start_q <= '0;
                done    <= 1'b0;
            end
            ACT_LOAD: begin
                start_q <= seed_word;
                done    <= 1'b0;
            end
            ACT_STEP: done <= (nxt == start_q);
            default:  done <= 1'b0;
        endcase
    end

    // R7: a done pulse only follows an enabled step
    a_r7_done_after_step: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(act) == ACT_STEP));
endmodule

// File: rtl/xnor_lfsr_gen.sv
module xnor_lfsr_gen
    import xlfsr_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic         seed_load,
    input  logic [W-1:0] seed_word,
    output logic [W-1:0] state,
    output logic         done
);
    localparam logic [W-1:0] ALL_ONES = '1;

    // R8: unsupported widths stop elaboration
    if (!width_ok(W)) begin : g_bad_width
        $error("xnor_lfsr_gen: width W=%0d outside supported range", W);
    end

    act_e         act;
    logic [W-1:0] nxt;

    xlfsr_ctl u_ctl (
        .rst       (rst),
        .step_en   (step_en),
        .seed_load (seed_load),
        .act       (act)
    );

    xlfsr_next #(.W(W)) u_next (
        .cur (state),
        .nxt (nxt)
    );

    xlfsr_period #(.W(W)) u_period (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .seed_word (seed_word),
        .nxt       (nxt),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        case (act)
            ACT_CLEAR: state <= '0;
            ACT_LOAD:  state <= seed_word;
            ACT_STEP:  state <= nxt;
            default:   state <= state;
        endcase
    end

    // R1: reset clears state and done
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (state == '0) && !done);

    // R3: no step, no load -> state frozen, no done
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !seed_load) |=> $stable(state) && !done);

    // R4: a load lands the seed and suppresses done
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (state == $past(seed_word)) && !done);

    // R6: all-ones only arrives by a load or by staying there
    a_r6_ones_origin: assert property (@(posedge clk) disable iff (rst)
        (state == ALL_ONES) |-> ($past(seed_load) || ($past(state) == ALL_ONES)));
endmodule

// File: tb/xnor_lfsr_gen_test.sv
`timescale 1ns/1ps
module xnor_lfsr_gen_test;
    localparam int W    = 5;
    localparam int PER  = (1 << W) - 1;
    localparam int ONES = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         step_en = 1'b0;
    logic         seed_load = 1'b0;
    logic [W-1:0] seed_word = '0;
    logic [W-1:0] state;
    logic         done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xnor_lfsr_gen #(.W(W)) uut (
        .clk(clk), .rst(rst), .step_en(step_en), .seed_load(seed_load),
        .seed_word(seed_word), .state(state), .done(done)
    );

    // Behavioural reference: integer arithmetic on the tap equation
    int    m_state = 0;
    int    m_start = 0;
    bit    m_done = 0;
    string m_tag = "R1";

    function automatic int ref_next(input int s);
        int fb;
        fb = (((s >> 4) & 1) ^ ((s >> 2) & 1)) ? 0 : 1;
        return ((s << 1) | fb) & ONES;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_start = 0; m_done = 0; m_tag = "R1";
        end else if (seed_load) begin
            m_state = int'(seed_word); m_start = int'(seed_word); m_done = 0; m_tag = "R4";
        end else if (step_en) begin
            m_state = ref_next(m_state);
            m_done  = (m_state == m_start);
            m_tag   = m_done ? "R7" : "R2";
        end else begin
            m_done = 0; m_tag = "R3";
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on the falling edge, then drive the next cycle's inputs.
    task automatic cyc(input bit r, input bit en, input bit ld, input int sd);
        @(negedge clk);
        check({m_tag, " state"}, int'(state), m_state);
        check({m_tag, " done"}, int'(done), int'(m_done));
        rst = r; step_en = en; seed_load = ld; seed_word = W'(sd);
    endtask

    int done_cnt;
    bit seen [0:ONES];

    initial begin
        // R1: reset
        cyc(1, 0, 0, 0);
        cyc(1, 1, 0, 0);
        cyc(0, 0, 0, 0);
        check("R1 reset state", int'(state), 0);
        check("R1 reset done", int'(done), 0);

        // R5/R6/R7: full period from zero
        foreach (seen[i]) seen[i] = 0;
        seen[0] = 1;
        done_cnt = 0;
        for (int k = 1; k <= PER; k++) begin
            cyc(0, 1, 0, 0);
            if (k > 1) begin
                if (int'(state) != 0) begin
                    check("R5 no repeat", int'(seen[int'(state)]), 0);
                    seen[int'(state)] = 1;
                end
                check("R6 never all-ones", int'(state == W'(ONES)), 0);
                if (done) done_cnt++;
            end
        end
        cyc(0, 0, 0, 0);
        check("R5 back to zero", int'(state), 0);
        if (done) done_cnt++;
        check("R7 one done per period", done_cnt, 1);

        // R3: idle cycles hold
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0);

        // R4: load with enable low, then with enable high
        cyc(0, 0, 1, 7);
        cyc(0, 1, 1, 19);
        // R7: period restarted from seed 19; enable gaps in the middle
        for (int k = 0; k < PER + 2; k++) cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 0);
        for (int k = 0; k < 10; k++) cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 0);
        for (int k = 0; k < PER; k++) cyc(0, (k % 3) != 0, 0, 0);

        // Collision: step that would end the period coincides with a load
        cyc(0, 0, 1, 9);
        for (int k = 0; k < PER - 1; k++) cyc(0, 1, 0, 0);
        cyc(0, 1, 1, 22);  // R4 load wins, done stays low
        cyc(0, 0, 0, 0);
        check("R4 collision state", int'(state), 22);
        check("R4 collision done", int'(done), 0);
        for (int k = 0; k < PER + 1; k++) cyc(0, 1, 0, 0);

        // R6: all-ones seed locks up
        cyc(0, 0, 1, ONES);
        for (int k = 0; k < 5; k++) cyc(0, 1, 0, 0);
        cyc(0, 0, 0, 0);
        check("R6 all-ones stuck", int'(state), ONES);

        // R1: reset mid-run
        cyc(1, 1, 0, 0);
        cyc(0, 0, 0, 0);
        check("R1 reset after run", int'(state), 0);
        cyc(0, 0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule